// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 2K words by 8 bits. The host offers one read or one write at a time through a request/ready handshake. The controller turns each request into a pin-level sequence of address, active-low chip select, active-low output enable and active-low write strobe. Every phase is long enough to meet the RAM's timing minimums.

All timing minimums are given as nanosecond parameters together with the clock period. Each one becomes a whole number of clock cycles by rounding up, with a floor of one cycle. The write strobe stays low long enough to cover both the minimum pulse width and the bus-release delay plus the data setup time. Write data goes onto the shared bus only after the RAM has had time to let go of it, and it leaves the bus on the same edge that ends the write. A read holds output enable low until both the address-access count and the enable-access count have run out. The data is then captured and returned with a one-cycle valid pulse. When a write follows a read, an extra bus turnaround phase is inserted. Between accesses the RAM is left deselected, in standby.

With the default 8 ns clock, the derived counts are:

| Count | Value |
|---|---|
| Write strobe | 2 cycles |
| Read wait | 1 cycle |
| Turnaround | 1 cycle |
| Bus-release wait | 1 cycle |

Top module: `sram_ctl`

## Requirements
- R1: During and right after synchronous reset, `ready`=1, `rd_valid`=0, `ram_ce_n`=`ram_oe_n`=`ram_we_n`=1 and `dq_oe`=0.
- R2: `ready` is high exactly when the controller is idle. A request is taken only on a clock edge where `req` and `ready` are both 1. A `req` raised while `ready`=0 and dropped again before `ready` returns starts no RAM access.
- R3: While `ready`=1, the RAM is in standby: `ram_ce_n`=1, `ram_oe_n`=1, `ram_we_n`=1, `dq_oe`=0.
- R4: `ram_a` loads the request address on the accepting edge, no later than `ram_ce_n` falls. It holds that value for as long as `ram_ce_n` is low.
- R5: A write drives `ram_we_n` low for PULSE = max(ceil(tWP/clk), ceil(tWZ/clk)+ceil(tDS/clk)) cycles, with `ram_ce_n` low and `ram_oe_n` high throughout. The RAM stores the value held on the bus when `ram_we_n` rises.
- R6: `dq_oe` is high only while `ram_we_n` is low. It rises ceil(tWZ/clk) cycles after `ram_we_n` falls and drops on the edge where `ram_we_n` rises. This leaves at least ceil(tDS/clk) cycles of stable `dq_out` before the end of the write.
- R7: A read holds `ram_oe_n` low for RW = max(ceil(tAA/clk)-1, ceil(tOE/clk)) cycles. The bus is captured on the edge that ends that wait. `rd_valid` is then 1 for exactly one cycle, with `rd_data` carrying the captured byte. If the request is accepted at edge a, `rd_valid` is high after edge a+1+RW and `ready` returns after edge a+2+RW.
- R8: A write whose previous access was a read waits an extra ceil(tHZ/clk) cycles before `ram_we_n` falls. A write after a write, or the first access after reset, does not wait. A write accepted at edge a returns `ready` after edge a+2+T+PULSE, where T is that turnaround count or 0. The controller never drives the bus while the RAM may still be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read, with `req` |
| addr | input | AW | Word address of the request |
| wdata | input | DW | Write data of the request |
| ready | output | 1 | Controller idle and able to take a request |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | DW | Captured read byte |
| ram_a | output | AW | RAM address pins |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| dq_out | output | DW | Data the controller drives onto the bus |
| dq_oe | output | 1 | Controller drives the bus when 1 |
| dq_in | input | DW | Data seen on the bus |

## Verification
The bench pairs the controller with a behavioural RAM model. The model returns a garbage byte until the address, chip-select and output-enable access counts have elapsed, so a read that captures one cycle early comes back with the wrong data. The model also measures every write strobe and the bus-drive window inside it, and flags any overlap with a RAM that may still be driving the bus. A short strobe, data driven before the bus is released, or data dropped before the end of the write is therefore reported. Read-then-write pairs, write-then-write pairs, repeated reads of the same address, and requests pulsed while the controller is busy are all exercised. A missing or spurious turnaround shows up as `ready` returning a cycle off, and a request taken while busy shows up as an extra chip-select pulse or corrupted data.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_TURN   = 3'd2,
    PH_STROBE = 3'd3,
    PH_WDONE  = 3'd4,
    PH_RWAIT  = 3'd5,
    PH_CAPT   = 3'd6
  } phase_e;

  // Round a nanosecond minimum up to whole cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int PULSE_C = 2,
  parameter int RDW_C   = 1,
  parameter int HZ_C    = 1,
  parameter int WZ_C    = 1,
  parameter int CW      = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   wr,
  output logic   accept,
  output logic   capture,
  output phase_e nxt,
  output logic   drive_nxt
);

  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_C - 1);
  localparam logic [CW-1:0] RDW_END   = CW'(RDW_C - 1);
  localparam logic [CW-1:0] HZ_END    = CW'(HZ_C - 1);
  localparam logic [CW-1:0] WZ_CNT    = CW'(WZ_C);

  phase_e        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          wr_q;
  logic          last_rd;

  always_comb begin
    nxt    = state;
    accept = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (req) begin
          accept = 1'b1;
          nxt    = PH_SETUP;
        end
      end
      PH_SETUP:  nxt = wr_q ? (last_rd ? PH_TURN : PH_STROBE) : PH_RWAIT;
      PH_TURN:   if (cnt == HZ_END) nxt = PH_STROBE;
      PH_STROBE: if (cnt == PULSE_END) nxt = PH_WDONE;
      PH_WDONE:  nxt = PH_IDLE;
      PH_RWAIT:  if (cnt == RDW_END) nxt = PH_CAPT;
      PH_CAPT:   nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    cnt_nxt   = (nxt != state) ? '0 : cnt + 1'b1;
    drive_nxt = (nxt == PH_STROBE) && (cnt_nxt >= WZ_CNT);
    capture   = (state == PH_RWAIT) && (nxt == PH_CAPT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      last_rd <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      if (accept) wr_q <= wr;
      if (nxt == PH_CAPT)  last_rd <= 1'b1;
      if (nxt == PH_WDONE) last_rd <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_ctl_pinreg.sv
module sram_ctl_pinreg
  import sram_ctl_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        nxt,
  input  logic          drive_nxt,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [AW-1:0] ram_a,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  logic sel_nxt;

  always_comb begin
    sel_nxt = (nxt == PH_SETUP) || (nxt == PH_TURN) || (nxt == PH_STROBE) ||
              (nxt == PH_WDONE) || (nxt == PH_RWAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      ram_ce_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_we_n <= 1'b1;
      dq_oe    <= 1'b0;
    end else begin
      ready    <= (nxt == PH_IDLE);
      ram_ce_n <= !sel_nxt;
      ram_oe_n <= (nxt != PH_RWAIT);
      ram_we_n <= (nxt != PH_STROBE);
      dq_oe    <= drive_nxt;
    end
  end

  // Address and data are plain enabled registers, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) begin
      ram_a  <= addr;
      dq_out <= wdata;
    end
  end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= capture;
  end

  always_ff @(posedge clk) begin
    if (capture) rd_data <= dq_in;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int CLK_NS  = 8,
  parameter int T_WP_NS = 8,
  parameter int T_DS_NS = 7,
  parameter int T_WZ_NS = 6,
  parameter int T_AA_NS = 10,
  parameter int T_OE_NS = 6,
  parameter int T_HZ_NS = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_a,
  output logic          ram_ce_n,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);

  localparam int WP_C    = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int DS_C    = ns_to_cyc(T_DS_NS, CLK_NS);
  localparam int WZ_C    = ns_to_cyc(T_WZ_NS, CLK_NS);
  localparam int AA_C    = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int OE_C    = ns_to_cyc(T_OE_NS, CLK_NS);
  localparam int HZ_C    = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int PULSE_C = imax(WP_C, WZ_C + DS_C);
  localparam int RDW_C   = imax(AA_C - 1, OE_C);
  localparam int MAX_C   = imax(PULSE_C, imax(RDW_C, HZ_C));
  localparam int CW      = $clog2(MAX_C + 1);

  logic   accept;
  logic   capture;
  logic   drive_nxt;
  phase_e nxt;

  sram_ctl_seq #(
    .PULSE_C(PULSE_C), .RDW_C(RDW_C), .HZ_C(HZ_C), .WZ_C(WZ_C), .CW(CW)
  ) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr(wr),
    .accept(accept), .capture(capture), .nxt(nxt), .drive_nxt(drive_nxt)
  );

  sram_ctl_pinreg #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .nxt(nxt), .drive_nxt(drive_nxt), .accept(accept),
    .addr(addr), .wdata(wdata), .ready(ready), .ram_a(ram_a),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  sram_ctl_rdcap #(.DW(DW)) u_rdcap (
    .clk(clk), .rst(rst), .capture(capture), .dq_in(dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          rd_valid,
  input logic [AW-1:0] ram_a,
  input logic          ram_ce_n,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic          dq_oe
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ready && !rd_valid && ram_ce_n && ram_oe_n && ram_we_n && !dq_oe));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |-> !ready);

  p_standby_r3: assert property (@(posedge clk) disable iff (rst)
    ready |-> (ram_ce_n && ram_oe_n && ram_we_n && !dq_oe));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ram_ce_n && !$past(ram_ce_n)) |-> $stable(ram_a));

  p_strobe_selected_r5: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_ce_n && ram_oe_n));

  p_drive_in_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !ram_we_n);

  p_drive_late_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> !dq_oe);

  p_drive_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_we_n) |-> !dq_oe);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_valid_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!ram_oe_n) && ram_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .rd_valid(rd_valid), .ram_a(ram_a),
  .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .dq_oe(dq_oe)
);

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;

  localparam int CLK = 8;
  localparam int AWB = 11;
  localparam int WP = (8 + CLK - 1) / CLK;
  localparam int DS = (7 + CLK - 1) / CLK;
  localparam int WZ = (6 + CLK - 1) / CLK;
  localparam int AA = (10 + CLK - 1) / CLK;
  localparam int OE = (6 + CLK - 1) / CLK;
  localparam int HZ = (6 + CLK - 1) / CLK;
  localparam int PULSE = (WP > WZ + DS) ? WP : WZ + DS;
  localparam int RW = (AA - 1 > OE) ? AA - 1 : OE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic wr = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, rd_valid, ram_ce_n, ram_oe_n, ram_we_n, dq_oe;
  logic [7:0] rd_data, dq_out, dq_in;
  logic [10:0] ram_a;

  sram_ctl dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data), .ram_a(ram_a),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #(CLK / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] mem [2048];
  logic [7:0] refm [2048];
  bit   rd_ok = 0;
  int   ce_age = -1, oe_age = -1, a_age = 0, we_age = 0, drv = 0, tail = 0;
  logic [10:0] a_prev = '0;
  logic prev_ce = 1, prev_oe = 1, prev_we = 1;
  logic [7:0] last_d = '0;

  assign dq_in = rd_ok ? mem[ram_a] : 8'hEE;

  always @(negedge clk) begin
    if (rst) begin
      rd_ok = 0; ce_age = -1; oe_age = -1; tail = 0;
      prev_ce = 1; prev_oe = 1; prev_we = 1;
    end else begin
      bit active, ram_drv;
      ce_age = ram_ce_n ? -1 : (prev_ce ? 0 : ce_age + 1);
      oe_age = ram_oe_n ? -1 : (prev_oe ? 0 : oe_age + 1);
      a_age  = (ram_a != a_prev) ? 0 : a_age + 1;
      a_prev = ram_a;
      active  = !ram_ce_n && !ram_oe_n && ram_we_n;
      ram_drv = active || (tail > 0);
      rd_ok = active && (ce_age + 1 >= AA) && (a_age + 1 >= AA) && (oe_age + 1 >= OE);
      if (active) tail = HZ; else if (tail > 0) tail--;
      if (!ram_we_n) begin
        if (prev_we) begin we_age = 0; drv = 0; end else we_age++;
        chk(!ram_ce_n && ram_oe_n, "R5", "strobe without select or with OE low",
            {ram_ce_n, ram_oe_n}, 2'b01);
        if (dq_oe) begin
          chk(we_age >= WZ, "R6", "bus driven before release", we_age, WZ);
          drv++;
          last_d = dq_out;
        end
      end else if (!prev_we) begin
        chk(we_age + 1 >= WP, "R5", "write strobe too short", we_age + 1, WP);
        chk(drv >= DS, "R6", "data setup too short", drv, DS);
        mem[ram_a] = last_d;
      end
      if (dq_oe) begin
        chk(!ram_we_n, "R6", "drive with strobe high", ram_we_n, 0);
        chk(!ram_drv, "R8", "bus contention", ram_drv, 0);
      end
      prev_ce = ram_ce_n; prev_oe = ram_oe_n; prev_we = ram_we_n;
    end
  end

  // ---------------- reference handshake model ----------------
  int idle_at = 0;
  int rdv_at = -1;
  logic [7:0] exp_data = '0;
  logic [10:0] cur_a = '0;
  logic [7:0] cur_d = '0;
  string tlab = "R2";
  bit last_read = 0;
  int accepted = 0;
  int ce_falls = 0;
  logic mon_prev_ce = 1;

  always @(posedge clk) if (!rst) cyc++;

  always @(negedge clk) begin
    if (!rst) begin
      chk(ready == (cyc >= idle_at), tlab, "ready timing", ready, cyc >= idle_at);
      chk(rd_valid == (cyc == rdv_at), "R7", "rd_valid timing", rd_valid, cyc == rdv_at);
      if (cyc == rdv_at)
        chk(rd_data == exp_data, "R7", "read data", rd_data, exp_data);
      if (ready)
        chk(ram_ce_n && ram_oe_n && ram_we_n && !dq_oe, "R3", "standby pins",
            {ram_ce_n, ram_oe_n, ram_we_n, dq_oe}, 4'b1110);
      if (!ram_ce_n)
        chk(ram_a == cur_a, "R4", "address while selected", ram_a, cur_a);
      if (dq_oe)
        chk(dq_out == cur_d, "R6", "write data on bus", dq_out, cur_d);
      if (mon_prev_ce && !ram_ce_n) ce_falls++;
      mon_prev_ce = ram_ce_n;
    end
  end

  task automatic do_op(input bit w, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    while (!ready) begin @(negedge clk); #1; end
    req = 1; wr = w; addr = a; wdata = d;
    begin
      int acc;
      acc = cyc + 1;
      cur_a = a; cur_d = d;
      accepted++;
      if (w) begin
        int t;
        t = last_read ? HZ : 0;
        tlab = last_read ? "R8" : "R5";
        idle_at = acc + 2 + t + PULSE;
        refm[a] = d;
        last_read = 0;
      end else begin
        tlab = "R7";
        rdv_at = acc + 1 + RW;
        exp_data = refm[a];
        idle_at = acc + 2 + RW;
        last_read = 1;
      end
    end
    @(negedge clk); #1;
    req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (!ready) begin @(negedge clk); #1; end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'(i * 7) ^ 8'h5A;
      refm[i] = mem[i];
    end
  end

  initial begin
    #(CLK * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(ready && !rd_valid && ram_ce_n && ram_oe_n && ram_we_n && !dq_oe, "R1", "reset outputs",
        {ready, rd_valid, ram_ce_n, ram_oe_n, ram_we_n, dq_oe}, 6'b101110);
    rst = 0;
    // R5: first write after reset needs no turnaround; writes back to back
    do_op(1, 11'h000, 8'hA5);
    do_op(1, 11'h7FF, 8'h3C);
    do_op(1, 11'h155, 8'h00);
    do_op(1, 11'h2AA, 8'hFF);
    // R7: read back, plus an untouched address
    do_op(0, 11'h000, 8'h00);
    do_op(0, 11'h7FF, 8'h00);
    do_op(0, 11'h155, 8'h00);
    do_op(0, 11'h2AA, 8'h00);
    do_op(0, 11'h007, 8'h00);
    // R8: write right after read gets the turnaround
    do_op(0, 11'h155, 8'h00);
    do_op(1, 11'h155, 8'h81);
    do_op(0, 11'h155, 8'h00);
    // R2: request pulsed while busy is ignored
    do_op(0, 11'h2AA, 8'h00);
    req = 1; wr = 1; addr = 11'h100; wdata = 8'h77;
    @(negedge clk); #1;
    req = 0;
    wait_idle();
    do_op(0, 11'h100, 8'h00);
    // R7: same address read twice in a row
    do_op(0, 11'h7FF, 8'h00);
    do_op(0, 11'h7FF, 8'h00);
    // mixed traffic
    for (int i = 0; i < 60; i++)
      do_op(i % 3 != 0, 11'((i * 389 + 17) % 2048), 8'(i * 29 + 3));
    for (int i = 0; i < 60; i += 5)
      do_op(0, 11'((i * 389 + 17) % 2048), 8'h00);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(ce_falls == accepted, "R2", "select pulses vs accepted requests", ce_falls, accepted);
    for (int i = 0; i < 2048; i += 97)
      chk(mem[i] == refm[i], "R5", "array contents", mem[i], refm[i]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule